// File: doc/BRIEF.md
# Continuous-Conversion ADC Result Readout

This block is the serial readback side of an ADC that converts continuously. A conversion timer counts modulator clock ticks (a one-cycle `mod_tick` enable in the system clock domain). At the end of every period of `CONV_PERIOD` ticks it captures the 24-bit word on `conv_data` as a new conversion result. The result waits in a buffer for an SPI mode 1 host (CPOL=0, CPHA=1). The host can read it in two ways. It can clock out the 24 bits straight away, or it can send a one-byte read command first and then clock out 24 bits. An active-low data-ready output tells the host whether a fresh result is waiting.

A read never sees a torn word. While a frame is in progress the buffer is frozen, and any result that completes in the meantime is parked. The parked result is committed when chip select rises, and data-ready falls for it then. The one exception is a read command: when the command byte ends, the shift register is reloaded with the newest completed result, parked or not. If no host reads, data-ready stays low but rises for exactly two modulator ticks just before each new result lands, so an edge-triggered host still sees a falling edge for every conversion.

The three host pins are brought into the system clock through synchronisers. All SPI edges are detected in that domain. The SPI pins carry no flow control. The serial data output is qualified by its own enable pin, which the pad uses to tri-state the line while chip select is high.

Top module: `adc_readout`

## Requirements
- R1: Each time a conversion result is written into the buffer outside a frame, `drdy_n` is low in the following cycle. With no reads, results (and `drdy_n` falling edges) occur exactly every `CONV_PERIOD` modulator ticks.
- R2: The first synchronised SCLK rising edge of a frame drives `drdy_n` high, and it stays high for the rest of that frame.
- R3: When no read takes place, `drdy_n` goes high for exactly 2 modulator ticks (`PULSE_MOD`) and falls in the same cycle that the next result is written.
- R4: `drdy_n` is always driven to a known level, including while `cs_n` is high. From reset until the first result it is high.
- R5: `dout` changes only after SCLK rising edges and holds its value across SCLK falling edges, so the host samples on falling edges.
- R6: In a direct read (DIN held at 0xFF), the 24 bits returned MSB first are the result that was in the buffer at the first SCLK rising edge.
- R7: If the first DIN byte, sampled MSB first on falling edges, is 0x10, the 9th rising edge reloads the shift register with the most recent completed result. Bits 9 to 32 return that result MSB first.
- R8: A conversion that completes during a frame does not change the data being shifted out. A direct read then returns the previous result.
- R9: A result that was held back during a frame is written into the buffer when `cs_n` rises, `drdy_n` falls for it, and the next read returns it.
- R10: With a read command, a conversion that completes during the command byte is the one shifted out, and `drdy_n` is still high after the frame. A conversion that completes during the data bits leaves the old result in the data, and `drdy_n` is low after the frame.
- R11: When no conversion completes between two reads, both reads return the same result.
- R12: While `cs_n` is high, `dout_oe` is low and the bit counter is cleared. An aborted partial frame has no effect on the bit alignment of the next frame.
- R13: A first DIN byte other than 0x10 (for example 0xFF or 0x11) causes no reload, and the frame continues as a direct read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_tick | input | 1 | One-cycle enable per modulator clock period |
| conv_data | input | DATA_W | Conversion word from the filter, captured at the end of each period |
| cs_n | input | 1 | SPI chip select, active low (asynchronous) |
| sclk | input | 1 | SPI clock, idle low (asynchronous) |
| din | input | 1 | SPI data from the host |
| dout | output | 1 | SPI data to the host, valid while `dout_oe` is high |
| dout_oe | output | 1 | Output enable for the `dout` pad; low while chip select is high |
| drdy_n | output | 1 | Data-ready, active low, always driven |

## Verification
The hardest case to reach from the ports is a conversion that lands inside a particular phase of a frame: before the first clock, inside the command byte, or inside the data bits. The bench drives the modulator ticks itself and records the cycle of every conversion. It places each frame start at a chosen offset from the last conversion, so that the new result lands in the phase under test, with a margin that is larger than the synchroniser latency. Random frames then draw their start point, read mode and SCLK rate. Draws whose edges would sit too close to a conversion or to the data-ready pulse are rejected. The expected word and data-ready level come from the recorded conversion history.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;

  // Command byte that requests a reload of the newest completed result.
  localparam logic [7:0] RD_OPCODE = 8'h10;

  // Per-cycle events from the serial port to the result buffer.
  typedef struct packed {
    logic first_rise;  // first SCLK rise of a frame
    logic reload;      // read command decoded at the byte boundary
    logic frame_end;   // chip select released after an active frame
    logic lock;        // buffer must not change this cycle
  } spi_evt_t;

endpackage

// File: rtl/adc_rb_sync.sv
module adc_rb_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/adc_rb_timer.sv
module adc_rb_timer #(
  parameter int CONV_PERIOD = 16,
  parameter int PULSE_MOD   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mod_tick,
  output logic conv_done,
  output logic in_window
);

  localparam int            CW        = $clog2(CONV_PERIOD);
  localparam logic [CW-1:0] LAST      = CW'(CONV_PERIOD - 1);
  localparam logic [CW-1:0] WIN_START = CW'(CONV_PERIOD - PULSE_MOD);
  localparam int            WT_W      = $clog2(PULSE_MOD + 2) + 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (mod_tick) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign conv_done = mod_tick && (cnt_q == LAST);
  assign in_window = (cnt_q >= WIN_START);

  // Checker: modulator ticks seen while the pre-result window is open.
  logic [WT_W-1:0] win_ticks;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          win_ticks <= '0;
    else if (!in_window) win_ticks <= '0;
    else if (mod_tick)   win_ticks <= win_ticks + 1'b1;
  end

  p_window_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_ticks <= WT_W'(PULSE_MOD));

  p_window_ends_on_conv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_window) |-> $past(conv_done));

endmodule

// File: rtl/adc_rb_buffer.sv
module adc_rb_buffer
  import adc_rb_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              in_window,
  input  spi_evt_t          evt,
  output logic [DATA_W-1:0] held,
  output logic [DATA_W-1:0] latest,
  output logic              drdy_n
);

  logic [DATA_W-1:0] res_q;
  logic [DATA_W-1:0] pend_q;
  logic              pend_v;
  logic              drdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      pend_q <= '0;
      pend_v <= 1'b0;
      drdy_q <= 1'b1;
    end else begin
      if (evt.first_rise) drdy_q <= 1'b1;
      // read command takes the parked result as the newest one
      if (evt.reload && pend_v) begin
        res_q  <= pend_q;
        pend_v <= 1'b0;
      end
      // deferred commit when the frame closes
      if (evt.frame_end && pend_v) begin
        res_q  <= pend_q;
        pend_v <= 1'b0;
        drdy_q <= 1'b0;
      end
      // new conversion: park it during a frame, commit it otherwise
      if (conv_done) begin
        if (evt.lock) begin
          pend_q <= conv_data;
          pend_v <= 1'b1;
        end else begin
          res_q  <= conv_data;
          drdy_q <= 1'b0;
        end
      end
    end
  end

  assign held   = res_q;
  assign latest = pend_v ? pend_q : res_q;
  assign drdy_n = drdy_q | in_window;

  p_first_rise_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt.first_rise |=> drdy_q);

  p_buf_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.lock && !evt.reload) |=> $stable(res_q));

  p_deferred_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.frame_end && pend_v && !conv_done) |=> (!drdy_q && res_q == $past(pend_q)));

endmodule

// File: rtl/adc_rb_spi.sv
module adc_rb_spi
  import adc_rb_pkg::*;
#(
  parameter int               DATA_W  = 24,
  parameter int               CMD_W   = 8,
  parameter logic [CMD_W-1:0] READ_OP = CMD_W'(RD_OPCODE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_s,
  input  logic              din_s,
  input  logic [DATA_W-1:0] held,
  input  logic [DATA_W-1:0] latest,
  output logic              dout_bit,
  output logic              dout_oe,
  output spi_evt_t          evt
);

  localparam int               CNT_W = $clog2(DATA_W + CMD_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CMD_END = CNT_W'(CMD_W);

  logic              sclk_q;
  logic              frame_active;
  logic [CNT_W-1:0]  bit_cnt;
  logic [CMD_W-1:0]  cmd_sr;
  logic [DATA_W-1:0] shreg;
  logic              rise, fall, first_rise, reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  assign rise       = sclk_s & ~sclk_q & ~cs_s;
  assign fall       = ~sclk_s & sclk_q & ~cs_s;
  assign first_rise = rise & ~frame_active;
  assign reload     = rise & (bit_cnt == CMD_END) & (cmd_sr == READ_OP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_active <= 1'b0;
      bit_cnt      <= '0;
      cmd_sr       <= '0;
    end else if (cs_s) begin
      frame_active <= 1'b0;
      bit_cnt      <= '0;
      cmd_sr       <= '0;
    end else begin
      if (rise) begin
        frame_active <= 1'b1;
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
      end
      if (fall && bit_cnt != '0 && bit_cnt <= CMD_END)
        cmd_sr <= {cmd_sr[CMD_W-2:0], din_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          shreg <= '0;
    else if (first_rise) shreg <= held;
    else if (reload)     shreg <= latest;
    else if (rise)       shreg <= {shreg[DATA_W-2:0], 1'b0};
  end

  assign dout_bit       = shreg[DATA_W-1];
  assign dout_oe        = ~cs_s;
  assign evt.first_rise = first_rise;
  assign evt.reload     = reload;
  assign evt.frame_end  = frame_active & cs_s;
  assign evt.lock       = (frame_active & ~cs_s) | first_rise;

  p_dout_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && !rise) |=> $stable(dout_bit));

  p_cs_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (bit_cnt == '0 && !frame_active));

endmodule

// File: rtl/adc_readout.sv
module adc_readout
  import adc_rb_pkg::*;
#(
  parameter int               DATA_W      = 24,
  parameter int               CONV_PERIOD = 16,
  parameter int               PULSE_MOD   = 2,
  parameter int               SYNC_STAGES = 2,
  parameter int               CMD_W       = 8,
  parameter logic [CMD_W-1:0] READ_OP     = CMD_W'(RD_OPCODE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_tick,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe,
  output logic              drdy_n
);

  logic [2:0]        pins_raw, pins_s;
  logic              conv_done, in_window;
  logic [DATA_W-1:0] held, latest;
  spi_evt_t          evt;

  assign pins_raw = {cs_n, sclk, din};

  adc_rb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b101)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  adc_rb_timer #(.CONV_PERIOD(CONV_PERIOD), .PULSE_MOD(PULSE_MOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .mod_tick(mod_tick),
    .conv_done(conv_done), .in_window(in_window)
  );

  adc_rb_spi #(.DATA_W(DATA_W), .CMD_W(CMD_W), .READ_OP(READ_OP)) u_spi (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[1]), .cs_s(pins_s[2]), .din_s(pins_s[0]),
    .held(held), .latest(latest),
    .dout_bit(dout), .dout_oe(dout_oe), .evt(evt)
  );

  adc_rb_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
    .in_window(in_window), .evt(evt),
    .held(held), .latest(latest), .drdy_n(drdy_n)
  );

  p_new_result_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !evt.lock && !evt.first_rise) |=> !drdy_n);

  p_drdy_known_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(drdy_n));

endmodule

// File: tb/tb_adc_readout.sv
module tb_adc_readout;

  localparam int CLK_PERIOD = 10;
  localparam int MOD_DIV    = 4;
  localparam int CONV_P     = 96;
  localparam int PULSE      = 2;
  localparam int T          = CONV_P * MOD_DIV;

  logic        clk = 1'b0;
  logic        rst_n, mod_tick, cs_n, sclk, din;
  logic [23:0] conv_data;
  logic        dout, dout_oe, drdy_n;

  int          cyc = 0;
  int          conv_t [512];
  logic [23:0] conv_v [512];
  int          n_conv = 0;
  int          n_checks = 0, n_fail = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_readout #(.DATA_W(24), .CONV_PERIOD(CONV_P), .PULSE_MOD(PULSE)) dut (
    .clk(clk), .rst_n(rst_n), .mod_tick(mod_tick), .conv_data(conv_data),
    .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout), .dout_oe(dout_oe), .drdy_n(drdy_n)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] latest_before(input int t);
    logic [23:0] v = '0;
    for (int i = 0; i < n_conv; i++) if (conv_t[i] < t) v = conv_v[i];
    return v;
  endfunction

  function automatic bit conv_between(input int a, input int b);
    for (int i = 0; i < n_conv; i++) if (conv_t[i] > a && conv_t[i] < b) return 1;
    return 0;
  endfunction

  function automatic int iabs(input int x);
    return (x < 0) ? -x : x;
  endfunction

  // modulator ticks and conversion stimulus
  initial begin
    int divc = 0;
    int tickno = 0;
    mod_tick  = 1'b0;
    conv_data = 24'h0;
    void'($urandom(32'h5eed_1234));
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      divc++;
      if (divc == MOD_DIV) begin
        divc = 0;
        mod_tick = 1'b1;
        tickno++;
        if (tickno % CONV_P == 0) begin
          conv_t[n_conv] = cyc;
          conv_v[n_conv] = conv_data;
          n_conv++;
        end else if (tickno % CONV_P == CONV_P / 2) begin
          conv_data = 24'($urandom);
        end
      end else begin
        mod_tick = 1'b0;
      end
    end
  end

  task automatic wait_phase(input int p);
    wait (n_conv > 0);
    forever begin
      @(negedge clk);
      if (cyc - conv_t[n_conv-1] == p) break;
    end
  endtask

  // one SPI frame; checks data, falling-edge stability, end state
  task automatic do_read(input bit use_cmd, input logic [7:0] first_byte,
                         input int H, input string tag, output logic [23:0] data);
    int nbits = use_cmd ? 32 : 24;
    logic [31:0] word = use_cmd ? {first_byte, 24'hFFFFFF} : {8'h00, first_byte, 16'hFFFF};
    logic [31:0] got = '0;
    int t0 = 0, tb = 0, te, tref;
    bit stable_ok = 1;
    logic d_a;
    logic [23:0] exp;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      din = word[nbits-1-i];
      sclk = 1'b1;
      if (i == 0) t0 = cyc;
      if (i == 8) tb = cyc;
      repeat (H) @(negedge clk);
      d_a = dout;
      got = {got[30:0], dout};
      sclk = 1'b0;
      repeat (H) @(negedge clk);
      if (dout !== d_a) stable_ok = 0;
    end
    cs_n = 1'b1;
    din  = 1'b1;
    te   = cyc;
    data = got[23:0];
    tref = (use_cmd && first_byte == 8'h10) ? tb : t0;
    exp  = latest_before(tref);
    check(data == exp, tag, "read data", {8'h0, data}, {8'h0, exp});
    check(stable_ok, "R5", "dout moved on falling edge", {31'h0, stable_ok}, 32'h1);
    repeat (8) @(negedge clk);
    check(drdy_n == !conv_between(tref, te), tag, "drdy_n after frame",
          {31'h0, drdy_n}, {31'h0, !conv_between(tref, te)});
    check(dout_oe == 1'b0, "R12", "dout_oe with cs high", {31'h0, dout_oe}, 32'h0);
  endtask

  function automatic bit safe_start(input bit use_cmd, input int H);
    int t0p = cyc + 1 + H;
    int tbp = t0p + 16 * H;
    int tep = t0p + (use_cmd ? 32 : 24) * 2 * H;
    int last = (n_conv > 0) ? conv_t[n_conv-1] : 0;
    for (int k = 0; k < 3; k++) begin
      int c = last + k * T;
      if (iabs(c - t0p) <= 12) return 0;
      if (use_cmd && iabs(c - tbp) <= 12) return 0;
      if (c > tep - 12 && c < tep + 30) return 0;
    end
    return 1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog all-requirements: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] r1, r2, r3;
    int tf1, tf2, hi_cnt;
    bit prev_hi;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; din = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // reset state
    check(drdy_n == 1'b1, "R4", "drdy_n before first result", {31'h0, drdy_n}, 32'h1);
    check(dout_oe == 1'b0, "R12", "dout_oe after reset", {31'h0, dout_oe}, 32'h0);

    // first result lands
    wait_phase(2);
    check(drdy_n == 1'b0, "R1", "drdy_n after first result", {31'h0, drdy_n}, 32'h0);
    check(drdy_n == 1'b0, "R4", "drdy_n driven low with cs high", {31'h0, drdy_n}, 32'h0);

    // direct read, then a repeat with no conversion in between
    wait_phase(10);
    do_read(0, 8'hFF, 3, "R6", r1);
    wait_phase(180);
    do_read(0, 8'hFF, 3, "R11", r2);
    check(r1 == r2, "R11", "repeat read equal", {8'h0, r2}, {8'h0, r1});

    // conversion during a direct read: old data, deferred commit
    wait_phase(250);
    do_read(0, 8'hFF, 4, "R8", r1);
    check(r1 == conv_v[n_conv-2], "R8", "previous result returned", {8'h0, r1},
          {8'h0, conv_v[n_conv-2]});
    wait_phase(100);
    do_read(0, 8'hFF, 4, "R9", r2);
    check(r2 == conv_v[n_conv-1], "R9", "deferred result read next", {8'h0, r2},
          {8'h0, conv_v[n_conv-1]});

    // unread period: pulse width and spacing
    wait (drdy_n == 1'b0);
    @(negedge clk);
    tf1 = cyc;
    hi_cnt = 0;
    prev_hi = 0;
    forever begin
      @(negedge clk);
      if (drdy_n) hi_cnt++;
      if (prev_hi && !drdy_n) break;
      prev_hi = drdy_n;
    end
    tf2 = cyc;
    check(hi_cnt == PULSE * MOD_DIV, "R3", "pre-result pulse cycles", hi_cnt, PULSE * MOD_DIV);
    check(tf2 - tf1 == T, "R1", "result spacing cycles", tf2 - tf1, T);

    // read command: conversion inside the command byte, then inside data
    wait_phase(340);
    do_read(1, 8'h10, 4, "R10", r1);
    check(r1 == conv_v[n_conv-1], "R10", "new result via command", {8'h0, r1},
          {8'h0, conv_v[n_conv-1]});
    check(drdy_n == 1'b1, "R10", "drdy_n high after new sent", {31'h0, drdy_n}, 32'h1);
    wait_phase(250);
    do_read(1, 8'h10, 4, "R10", r2);
    check(r2 == conv_v[n_conv-2], "R10", "old result via command", {8'h0, r2},
          {8'h0, conv_v[n_conv-2]});
    check(drdy_n == 1'b0, "R10", "drdy_n low after old sent", {31'h0, drdy_n}, 32'h0);

    // read command with no conversion in the frame
    wait_phase(10);
    do_read(1, 8'h10, 4, "R7", r3);

    // aborted frame, then a read whose first byte is not the opcode
    wait_phase(10);
    check(drdy_n == 1'b0, "R1", "drdy_n low before abort", {31'h0, drdy_n}, 32'h0);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b1; repeat (3) @(negedge clk);
      sclk = 1'b0; repeat (3) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    check(drdy_n == 1'b1, "R2", "drdy_n high after aborted frame", {31'h0, drdy_n}, 32'h1);
    check(dout_oe == 1'b0, "R12", "dout_oe after abort", {31'h0, dout_oe}, 32'h0);
    do_read(0, 8'h11, 3, "R13", r1);
    check(r1 == conv_v[n_conv-1], "R12", "alignment after abort", {8'h0, r1},
          {8'h0, conv_v[n_conv-1]});

    // random frames
    for (int k = 0; k < 12; k++) begin
      bit uc = 1'($urandom % 2);
      int H = 3 + int'($urandom % 2);
      int guard = 0;
      repeat (int'($urandom % 200)) @(negedge clk);
      while (!safe_start(uc, H) && guard < 1000) begin
        @(negedge clk);
        guard++;
      end
      do_read(uc, uc ? 8'h10 : 8'hFF, H, uc ? "R7 random" : "R6 random", r1);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule